// File: doc/BRIEF.md
# Unit Reset Sequencer with Clock Gating Control

This block holds the clock-enable bit and the active-low reset bit of every peripheral unit in a group. Software manipulates these bits through a small register port. Each control register works as write-1-to-set or write-1-to-clear, so changing one unit never requires a read-modify-write of the others. Two status addresses return the current clock-enable and reset vectors.

The block can also reset one unit by itself, so that software does not have to time the steps. A request carrying a unit index starts the sequence. The block pulls that unit's reset low and switches its clock on, keeps both for a fixed number of cycles, and turns the clock off. It then lets reset go high and puts the clock enable back to the value it had before the request. While this runs, `busy` is high. Further requests are dropped, and software writes that target the unit being reset are masked. The gating cells that consume the enable vector sit outside this block.

Top module: `unit_rst_seq`

## Requirements
- R1: Following power-on reset, every bit of `unit_clk_en` is 0, every bit of `unit_rst_n` is 0 (all units held in reset), and `busy` and `req_err` are 0.
- R2: Clock control uses three byte addresses. A write to 0x00 sets each clock-enable bit whose data bit is 1, and a write to 0x04 clears each such bit. Bits written as 0 keep their value. A read at 0x08 returns the clock-enable vector.
- R3: Reset control uses three byte addresses. A write to 0x0C releases reset (bit goes to 1) for each data bit that is 1, and a write to 0x10 asserts reset (bit goes to 0) for each data bit that is 1. Other bits are unchanged. A read at 0x14 returns the `unit_rst_n` vector. Reads at any other address return 0.
- R4: A request with an in-range index, seen while idle, is accepted. One cycle later the target's `unit_rst_n` bit is 0, its `unit_clk_en` bit is 1 and `busy` is 1. Reset stays low for the whole hold window.
- R5: The target clock stays enabled for exactly HOLD_CYCLES cycles (16 by default), counted from the cycle after acceptance. The clock then turns off while reset is still asserted, for one cycle.
- R6: One cycle after the clock turns off, the target reset is released. One cycle after that, the target clock enable returns to its value at acceptance, and `busy` falls in that same cycle.
- R7: `busy` stays high from the cycle after acceptance through the restore step. A request presented while `busy` is high is ignored and raises no error.
- R8: A request presented while idle with an index at or above NUM_UNITS is ignored: no bit changes and `busy` stays 0. `req_err` is 1 for the following cycle only.
- R9: While a sequence is in progress, including the accepting cycle, register writes do not change the target unit's clock or reset bit. The same writes still update the bits of all other units.
- R10: The sequence changes only the target unit's bits. Every other unit's clock and reset bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address for writes and reads |
| reg_wdata | input | NUM_UNITS | Write data, one bit per unit |
| reg_rdata | output | NUM_UNITS | Read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Reset-sequence request strobe |
| req_unit | input | IDX_W | Index of the unit to reset |
| unit_clk_en | output | NUM_UNITS | Clock-enable vector to the gating cells |
| unit_rst_n | output | NUM_UNITS | Active-low reset vector to the units |
| busy | output | 1 | A reset sequence is in progress |
| req_err | output | 1 | One-cycle flag for a rejected out-of-range request |

## Verification
The sequence is started on one unit whose clock was on and on another whose clock was off. The first case separates restoring the saved state from always turning the clock off; the second separates it from always turning the clock back on. A third run places a competing request, a clear of the target clock, an assertion of the target reset and a set of an unrelated clock bit inside the hold window. This shows that masking applies to the target only and that requests are dropped while busy. An out-of-range index confirms that a rejected request leaves every bit alone and produces a single error pulse. A behavioural model tracks every output cycle by cycle, so any off-by-one in the 16-cycle window or in the release and restore steps is caught.

// File: rtl/urs_pkg.sv
package urs_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CLK_SET  = 5'h00;
    localparam logic [ADDR_W-1:0] A_CLK_CLR  = 5'h04;
    localparam logic [ADDR_W-1:0] A_CLK_STAT = 5'h08;
    localparam logic [ADDR_W-1:0] A_RST_REL  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_RST_ASRT = 5'h10;
    localparam logic [ADDR_W-1:0] A_RST_STAT = 5'h14;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_HOLD    = 2'd1,
        PH_RELEASE = 2'd2,
        PH_RESTORE = 2'd3
    } phase_e;

endpackage

// File: rtl/urs_decode.sv
module urs_decode
    import urs_pkg::*;
#(
    parameter int N = 6
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      clk_en_q,
    input  logic [N-1:0]      rstn_q,
    output logic [N-1:0]      clk_set,
    output logic [N-1:0]      clk_clr,
    output logic [N-1:0]      rst_rel,
    output logic [N-1:0]      rst_asrt,
    output logic [N-1:0]      rdata
);

    always_comb begin
        clk_set  = (wr_en && addr == A_CLK_SET)  ? wdata : '0;
        clk_clr  = (wr_en && addr == A_CLK_CLR)  ? wdata : '0;
        rst_rel  = (wr_en && addr == A_RST_REL)  ? wdata : '0;
        rst_asrt = (wr_en && addr == A_RST_ASRT) ? wdata : '0;
        case (addr)
            A_CLK_STAT: rdata = clk_en_q;
            A_RST_STAT: rdata = rstn_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/urs_seq.sv
module urs_seq
    import urs_pkg::*;
#(
    parameter int N     = 6,
    parameter int IDX_W = 3,
    parameter int HOLD  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_unit,
    input  logic [N-1:0]     clk_en_q,
    output logic             start,
    output logic             clk_off,
    output logic             rel_rst,
    output logic             restore,
    output logic             restore_val,
    output logic [N-1:0]     tgt_oh,
    output logic [N-1:0]     held_oh,
    output logic [N-1:0]     lock_oh,
    output logic             busy,
    output logic             in_hold,
    output logic             err
);

    localparam int              CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD - 1);
    localparam logic [IDX_W:0]   N_LIM = (IDX_W + 1)'(N);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] unit;
        logic             saved;
        logic             err;
    } seq_t;

    seq_t s_q, s_d;
    logic             in_range;
    logic [IDX_W-1:0] tgt_sel;

    always_comb begin
        s_d      = s_q;
        s_d.err  = 1'b0;
        start    = 1'b0;
        clk_off  = 1'b0;
        rel_rst  = 1'b0;
        restore  = 1'b0;
        in_range = ({1'b0, req_unit} < N_LIM);
        case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    if (in_range) begin
                        start     = 1'b1;
                        s_d.ph    = PH_HOLD;
                        s_d.cnt   = '0;
                        s_d.unit  = req_unit;
                        s_d.saved = clk_en_q[req_unit];
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == CNT_LAST) begin
                    clk_off = 1'b1;
                    s_d.ph  = PH_RELEASE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_RELEASE: begin
                rel_rst = 1'b1;
                s_d.ph  = PH_RESTORE;
            end
            default: begin
                restore = 1'b1;
                s_d.ph  = PH_IDLE;
            end
        endcase

        tgt_sel     = (s_q.ph == PH_IDLE) ? req_unit : s_q.unit;
        restore_val = s_q.saved;
        busy        = (s_q.ph != PH_IDLE);
        in_hold     = (s_q.ph == PH_HOLD);
        err         = s_q.err;
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_oh
        assign tgt_oh[gi]  = (tgt_sel == IDX_W'(gi));
        assign held_oh[gi] = (s_q.unit == IDX_W'(gi));
        assign lock_oh[gi] = (busy || start) && tgt_oh[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph    <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.unit  <= '0;
            s_q.saved <= 1'b0;
            s_q.err   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_LAST);

endmodule

// File: rtl/urs_bank.sv
module urs_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] clk_set,
    input  logic [N-1:0] clk_clr,
    input  logic [N-1:0] rst_rel,
    input  logic [N-1:0] rst_asrt,
    input  logic [N-1:0] lock_oh,
    input  logic [N-1:0] tgt_oh,
    input  logic         start,
    input  logic         clk_off,
    input  logic         rel_rst,
    input  logic         restore,
    input  logic         restore_val,
    output logic [N-1:0] clk_en_q,
    output logic [N-1:0] rstn_q
);

    typedef struct packed {
        logic [N-1:0] ce;
        logic [N-1:0] rn;
    } bank_t;

    bank_t b_q, b_d;

    always_comb begin
        b_d    = b_q;
        b_d.ce = (b_d.ce | (clk_set & ~lock_oh)) & ~(clk_clr & ~lock_oh);
        b_d.rn = (b_d.rn | (rst_rel & ~lock_oh)) & ~(rst_asrt & ~lock_oh);
        if (start) begin
            b_d.ce = b_d.ce | tgt_oh;
            b_d.rn = b_d.rn & ~tgt_oh;
        end
        if (clk_off) begin
            b_d.ce = b_d.ce & ~tgt_oh;
        end
        if (rel_rst) begin
            b_d.rn = b_d.rn | tgt_oh;
        end
        if (restore) begin
            b_d.ce = (b_d.ce & ~tgt_oh) | (restore_val ? tgt_oh : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.ce <= '0;
            b_q.rn <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign clk_en_q = b_q.ce;
    assign rstn_q   = b_q.rn;

    p_lock_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lock_oh));

endmodule

// File: rtl/unit_rst_seq.sv
module unit_rst_seq
    import urs_pkg::*;
#(
    parameter int NUM_UNITS   = 6,
    parameter int IDX_W       = 3,
    parameter int HOLD_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [NUM_UNITS-1:0] reg_wdata,
    output logic [NUM_UNITS-1:0] reg_rdata,
    input  logic                 req_valid,
    input  logic [IDX_W-1:0]     req_unit,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic [NUM_UNITS-1:0] unit_rst_n,
    output logic                 busy,
    output logic                 req_err
);

    logic [NUM_UNITS-1:0] clk_set, clk_clr, rst_rel, rst_asrt;
    logic [NUM_UNITS-1:0] tgt_oh, held_oh, lock_oh;
    logic start, clk_off, rel_rst, restore, restore_val, in_hold;

    urs_decode #(.N(NUM_UNITS)) u_decode (
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .clk_en_q (unit_clk_en),
        .rstn_q   (unit_rst_n),
        .clk_set  (clk_set),
        .clk_clr  (clk_clr),
        .rst_rel  (rst_rel),
        .rst_asrt (rst_asrt),
        .rdata    (reg_rdata)
    );

    urs_seq #(.N(NUM_UNITS), .IDX_W(IDX_W), .HOLD(HOLD_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_unit    (req_unit),
        .clk_en_q    (unit_clk_en),
        .start       (start),
        .clk_off     (clk_off),
        .rel_rst     (rel_rst),
        .restore     (restore),
        .restore_val (restore_val),
        .tgt_oh      (tgt_oh),
        .held_oh     (held_oh),
        .lock_oh     (lock_oh),
        .busy        (busy),
        .in_hold     (in_hold),
        .err         (req_err)
    );

    urs_bank #(.N(NUM_UNITS)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_set     (clk_set),
        .clk_clr     (clk_clr),
        .rst_rel     (rst_rel),
        .rst_asrt    (rst_asrt),
        .lock_oh     (lock_oh),
        .tgt_oh      (tgt_oh),
        .start       (start),
        .clk_off     (clk_off),
        .rel_rst     (rel_rst),
        .restore     (restore),
        .restore_val (restore_val),
        .clk_en_q    (unit_clk_en),
        .rstn_q      (unit_rst_n)
    );

    p_start_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ((unit_rst_n & held_oh) == '0) && ((unit_clk_en & held_oh) != '0));

    p_hold_rst_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold |-> ((unit_rst_n & held_oh) == '0));

    p_hold_clk_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold |-> ((unit_clk_en & held_oh) != '0));

    p_released_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ((unit_rst_n & held_oh) != '0));

    p_err_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !busy);

    p_busy_ignores_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !req_err);

endmodule

// File: tb/unit_rst_seq_bench.sv
`timescale 1ns/1ps
module unit_rst_seq_bench;

    localparam int N    = 6;
    localparam int IW   = 3;
    localparam int HOLD = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_unit = '0;
    logic [N-1:0]  unit_clk_en, unit_rst_n;
    logic          busy, req_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    unit_rst_seq #(.NUM_UNITS(N), .IDX_W(IW), .HOLD_CYCLES(HOLD)) u_unit_rst_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_unit(req_unit), .unit_clk_en(unit_clk_en), .unit_rst_n(unit_rst_n),
        .busy(busy), .req_err(req_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    logic [N-1:0] m_clk = '0, m_rst = '0;
    bit m_busy = 0, m_err = 0, m_saved = 0;
    int m_t = 0, m_u = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clk = '0; m_rst = '0; m_busy = 0; m_err = 0; m_t = 0; m_u = 0;
        end else begin
            logic [N-1:0] oc, orr, msk;
            bit was_busy, acc;
            oc = m_clk; orr = m_rst; was_busy = m_busy; acc = 0;
            m_err = 0;
            if (was_busy) begin
                m_t++;
                if (m_t == HOLD)     m_clk[m_u] = 1'b0;
                if (m_t == HOLD + 1) m_rst[m_u] = 1'b1;
                if (m_t == HOLD + 2) begin m_clk[m_u] = m_saved; m_busy = 0; end
            end else if (req_valid) begin
                if (int'(req_unit) < N) begin
                    acc = 1; m_u = int'(req_unit); m_saved = oc[m_u];
                    m_clk[m_u] = 1'b1; m_rst[m_u] = 1'b0; m_busy = 1; m_t = 0;
                end else m_err = 1;
            end
            msk = (was_busy || acc) ? (N'(1) << m_u) : '0;
            if (reg_wr) begin
                case (reg_addr)
                    5'h00: m_clk = m_clk | (reg_wdata & ~msk);
                    5'h04: m_clk = m_clk & ~(reg_wdata & ~msk);
                    5'h0C: m_rst = m_rst | (reg_wdata & ~msk);
                    5'h10: m_rst = m_rst & ~(reg_wdata & ~msk);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 model clk_en", unit_clk_en, m_clk);
            chk("R10 model rst_n", unit_rst_n, m_rst);
            chk("R7 model busy", busy, m_busy);
            chk("R8 model err", req_err, m_err);
        end
    end

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [N-1:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic req(input logic [IW-1:0] u);
        req_valid = 1'b1; req_unit = u;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 clk_en", unit_clk_en, '0);
        chk("R1 rst_n", unit_rst_n, '0);
        chk("R1 busy", busy, 0);
        chk("R1 err", req_err, 0);

        wr(5'h00, 6'h05);
        chk("R2 set", unit_clk_en, 6'h05);
        wr(5'h04, 6'h01);
        chk("R2 clear", unit_clk_en, 6'h04);
        rd(5'h08, 6'h04, "R2 status read");

        wr(5'h0C, 6'h3F);
        chk("R3 release", unit_rst_n, 6'h3F);
        wr(5'h10, 6'h02);
        chk("R3 assert", unit_rst_n, 6'h3D);
        rd(5'h14, 6'h3D, "R3 status read");
        rd(5'h18, 6'h00, "R3 unmapped read");
        wr(5'h0C, 6'h02);

        // unit 2, clock on beforehand
        req(3'd2);
        chk("R4 rst low", unit_rst_n[2], 0);
        chk("R4 clk on", unit_clk_en[2], 1);
        chk("R4 busy", busy, 1);
        chk("R10 others clk", unit_clk_en & 6'h3B, 6'h00);
        chk("R10 others rst", unit_rst_n & 6'h3B, 6'h3B);
        n = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!unit_clk_en[2]) break;
            n++;
        end
        chk("R5 hold length", n, HOLD);
        chk("R5 rst still low", unit_rst_n[2], 0);
        @(negedge clk);
        chk("R6 released", unit_rst_n[2], 1);
        chk("R6 busy during restore", busy, 1);
        @(negedge clk);
        chk("R6 clk restored on", unit_clk_en[2], 1);
        chk("R6 busy falls", busy, 0);

        // unit 0, clock off beforehand
        req(3'd0);
        chk("R4 clk forced on", unit_clk_en[0], 1);
        wait_idle();
        chk("R6 clk stays off", unit_clk_en[0], 0);
        chk("R6 rst released", unit_rst_n[0], 1);

        // unit 3 with interference during hold
        req(3'd3);
        req(3'd1);
        chk("R7 second request dropped", unit_rst_n[1], 1);
        chk("R7 no err when busy", req_err, 0);
        wr(5'h04, 6'h08);
        chk("R9 target clk kept", unit_clk_en[3], 1);
        wr(5'h00, 6'h10);
        chk("R9 other unit set", unit_clk_en[4], 1);
        wr(5'h10, 6'h08);
        wr(5'h0C, 6'h08);
        chk("R9 target rst kept low", unit_rst_n[3], 0);
        wait_idle();
        chk("R9 target rst after", unit_rst_n[3], 1);
        chk("R6 unit3 clk restored off", unit_clk_en[3], 0);
        chk("R7 unit1 untouched", unit_rst_n[1], 1);

        // out of range
        req(3'd7);
        chk("R8 err pulse", req_err, 1);
        chk("R8 not busy", busy, 0);
        chk("R8 clk unchanged", unit_clk_en, 6'h14);
        chk("R8 rst unchanged", unit_rst_n, 6'h3F);
        @(negedge clk);
        chk("R8 err single", req_err, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule